// File: doc/BRIEF.md
# Secure Access Filter With Fault Capture

This block sits on the path from an upstream bus to a downstream memory. For each request it decides whether the request may reach the memory. The decision uses a table with one bit per fixed-size block of the protected region. A table bit of one admits only non-secure requests to that block, and a table bit of zero admits only secure requests. A request whose security attribute is not known counts as secure.

Admitted requests go to the memory unchanged in the cycle they are presented. Refused requests never reach the memory. A refused read returns zero data and a refused write is dropped. A control input sets whether a refused request gets an error response or an OK response.

The first refused request after the fault flag was last cleared sets the fault flag and stores its address and attributes in two capture words. Later refusals are still refused, but they leave the capture words as they are until software clears the flag. The table contents, the error-response setting and the clear strobe all come from a register bank outside this block.

Top module: `sec_access_filter`

## Requirements
- R1: The block number of a request is `reqAddr[ADDR_W-1:BLK_LOG2]`. Its table bit is bit `blockNum % 32` of table word `blockNum / 32`. In the flattened `lutBits` vector this is bit `blockNum`.
- R2: If the table bit is 1, only requests with `reqNonSec`=1 pass. If it is 0, only secure requests pass.
- R3: When `reqAttrKnown`=0, the request is treated as secure, whatever the value of `reqNonSec`.
- R4: A passing request drives `memValid`, `memWrite`, `memAddr` and `memWdata` in the same cycle, with the request's values. One cycle later `rspValid`=1 and `rspErr`=0. For a read, `rspRdata` equals `memRdata` in that cycle.
- R5: A refused request never asserts `memValid`. Its response comes one cycle later with `rspRdata`=0, and a refused write leaves the memory contents unchanged.
- R6: A refused request's response has `rspErr`=1 when `errRespEn` was 1 in the request cycle. Otherwise `rspErr`=0.
- R7: A refused request seen while `faultStatus`=0 does three things, visible the next cycle. It sets `faultStatus`. It loads `capAddr` with the full request address. It loads `capInfo` with the master ID in bits [15:0], the effective non-secure flag in bit 16, the block's table bit in bit 17, and zero in the remaining bits.
- R8: While `faultStatus`=1, further refused requests do not change `capAddr` or `capInfo`.
- R9: `clrFault`=1 clears `faultStatus` on the next cycle. If the flag was already set, a refusal in that same cycle does not capture. The capture words keep their values when the flag is cleared.
- R10: After reset, `rspValid`, `rspErr` and `faultStatus` are 0, and `capAddr` and `capInfo` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Upstream request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte address within the protected region |
| reqWdata | input | DATA_W | Write data |
| reqNonSec | input | 1 | Request is non-secure |
| reqAttrKnown | input | 1 | Security attribute is specified |
| reqMaster | input | 16 | Requesting master ID |
| lutBits | input | LUT_BITS | Table contents, one bit per block |
| errRespEn | input | 1 | Refused requests get an error response |
| clrFault | input | 1 | Clear the fault flag |
| memValid | output | 1 | Downstream request strobe |
| memWrite | output | 1 | Downstream write |
| memAddr | output | ADDR_W | Downstream address |
| memWdata | output | DATA_W | Downstream write data |
| memRdata | input | DATA_W | Downstream read data, valid one cycle after `memValid` |
| rspValid | output | 1 | Upstream response |
| rspErr | output | 1 | Error response |
| rspRdata | output | DATA_W | Read data returned upstream |
| faultStatus | output | 1 | A refused request has been captured |
| capAddr | output | ADDR_W | Address of the captured refusal |
| capInfo | output | 32 | Master ID, non-secure flag and table bit of the captured refusal |

## Verification
A wrong block index or an inverted table bit shows up one cycle after the request. The response then carries data or an error where it should not, and `memValid` is wrong in the request cycle itself. A wrong fault flag shows in two ways. A capture word may be overwritten by a second refusal, or a refusal after a clear may not load it; either is visible on the capture outputs one cycle after that refusal. A refused write that leaks to the memory is caught later, when a permitted read of the same word returns the wrong data.

// File: rtl/saf_pkg.sv
package saf_pkg;

  localparam int MASTER_W = 16;
  localparam int INFO_W   = 32;

  typedef struct packed {
    logic fwd;      // request goes to downstream this cycle
    logic capture;  // load capture words this cycle
    logic useMem;   // response data comes from downstream
  } saf_strobe_t;

  function automatic logic [INFO_W-1:0] packInfo(
    input logic [MASTER_W-1:0] master,
    input logic                nonSec,
    input logic                cfgBit
  );
    logic [INFO_W-1:0] w;
    w = '0;
    w[MASTER_W-1:0] = master;
    w[16]           = nonSec;
    w[17]           = cfgBit;
    return w;
  endfunction

endpackage

// File: rtl/saf_ctrl.sv
module saf_ctrl
  import saf_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int BLK_LOG2 = 5,
  parameter int LUT_BITS = 128
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                reqNonSec,
  input  logic                reqAttrKnown,
  input  logic [LUT_BITS-1:0] lutBits,
  input  logic                errRespEn,
  input  logic                clrFault,
  output saf_strobe_t         strobe,
  output logic                reqIsNs,
  output logic                cfgBit,
  output logic                rspValid,
  output logic                rspErr,
  output logic                faultStatus
);

  localparam int BLK_NUM_W = ADDR_W - BLK_LOG2;

  logic [BLK_NUM_W-1:0] blockNum;
  logic allowed, passReq, blockReq, captureNow;
  logic pendValid, pendErr, pendMemRead, statusQ;

  // The flattened table index equals the block number (word*32 + bit).
  assign blockNum = reqAddr[ADDR_W-1:BLK_LOG2];
  assign cfgBit   = lutBits[blockNum];

  // A request with an unknown attribute counts as secure.
  assign reqIsNs  = reqAttrKnown & reqNonSec;
  assign allowed  = (cfgBit == reqIsNs);

  assign passReq    = reqValid & allowed;
  assign blockReq   = reqValid & ~allowed;
  assign captureNow = blockReq & ~statusQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid   <= 1'b0;
      pendErr     <= 1'b0;
      pendMemRead <= 1'b0;
      statusQ     <= 1'b0;
    end else begin
      pendValid   <= reqValid;
      pendErr     <= blockReq & errRespEn;
      pendMemRead <= passReq & ~reqWrite;
      if (captureNow)    statusQ <= 1'b1;
      else if (clrFault) statusQ <= 1'b0;
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.fwd     = passReq;
    strobe.capture = captureNow;
    strobe.useMem  = pendMemRead;
  end

  assign rspValid    = pendValid;
  assign rspErr      = pendErr;
  assign faultStatus = statusQ;

endmodule

// File: rtl/saf_dp.sv
module saf_dp
  import saf_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  saf_strobe_t         strobe,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [MASTER_W-1:0] reqMaster,
  input  logic                reqIsNs,
  input  logic                cfgBit,
  input  logic [DATA_W-1:0]   memRdata,
  output logic                memValid,
  output logic                memWrite,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  output logic [DATA_W-1:0]   rspRdata,
  output logic [ADDR_W-1:0]   capAddr,
  output logic [INFO_W-1:0]   capInfo
);

  assign memValid = strobe.fwd;
  assign memWrite = strobe.fwd & reqWrite;
  assign memAddr  = reqAddr;
  assign memWdata = reqWdata;

  assign rspRdata = strobe.useMem ? memRdata : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capAddr <= '0;
      capInfo <= '0;
    end else if (strobe.capture) begin
      capAddr <= reqAddr;
      capInfo <= packInfo(reqMaster, reqIsNs, cfgBit);
    end
  end

endmodule

// File: rtl/sec_access_filter.sv
module sec_access_filter
  import saf_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int BLK_LOG2 = 5,
  parameter int DATA_W   = 32,
  localparam int NUM_BLK  = 1 << (ADDR_W - BLK_LOG2),
  localparam int LUT_BITS = ((NUM_BLK + 31) / 32) * 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic                reqNonSec,
  input  logic                reqAttrKnown,
  input  logic [15:0]         reqMaster,
  input  logic [LUT_BITS-1:0] lutBits,
  input  logic                errRespEn,
  input  logic                clrFault,
  output logic                memValid,
  output logic                memWrite,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  input  logic [DATA_W-1:0]   memRdata,
  output logic                rspValid,
  output logic                rspErr,
  output logic [DATA_W-1:0]   rspRdata,
  output logic                faultStatus,
  output logic [ADDR_W-1:0]   capAddr,
  output logic [31:0]         capInfo
);

  saf_strobe_t strobe;
  logic reqIsNs, cfgBit;

  saf_ctrl #(.ADDR_W(ADDR_W), .BLK_LOG2(BLK_LOG2), .LUT_BITS(LUT_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqNonSec(reqNonSec), .reqAttrKnown(reqAttrKnown),
    .lutBits(lutBits), .errRespEn(errRespEn), .clrFault(clrFault),
    .strobe(strobe), .reqIsNs(reqIsNs), .cfgBit(cfgBit),
    .rspValid(rspValid), .rspErr(rspErr), .faultStatus(faultStatus)
  );

  saf_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMaster(reqMaster),
    .reqIsNs(reqIsNs), .cfgBit(cfgBit), .memRdata(memRdata),
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr),
    .memWdata(memWdata), .rspRdata(rspRdata), .capAddr(capAddr),
    .capInfo(capInfo)
  );

endmodule

// File: rtl/saf_checker.sv
module saf_checker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              errRespEn,
  input logic              clrFault,
  input logic              memValid,
  input logic              memWrite,
  input logic [ADDR_W-1:0] memAddr,
  input logic              rspValid,
  input logic              rspErr,
  input logic [DATA_W-1:0] rspRdata,
  input logic              faultStatus,
  input logic [ADDR_W-1:0] capAddr,
  input logic [31:0]       capInfo
);

  // R4
  fwd_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> (reqValid && memAddr == reqAddr && memWrite == reqWrite));

  // R4
  pass_ok_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    memValid |=> (rspValid && !rspErr));

  // R5
  blocked_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !memValid) |=> (rspValid && rspRdata == '0));

  // R6
  blocked_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !memValid) |=> (rspErr == $past(errRespEn)));

  // R6
  err_has_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> rspValid);

  // R7
  first_block_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !memValid && !faultStatus) |=> (faultStatus && capAddr == $past(reqAddr)));

  // R8
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultStatus |=> ($stable(capAddr) && $stable(capInfo)));

  // R9
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rstN)
    (faultStatus && clrFault) |=> !faultStatus);

endmodule

bind sec_access_filter saf_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_saf_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqAddr(reqAddr), .errRespEn(errRespEn), .clrFault(clrFault),
  .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr),
  .rspValid(rspValid), .rspErr(rspErr), .rspRdata(rspRdata),
  .faultStatus(faultStatus), .capAddr(capAddr), .capInfo(capInfo)
);

// File: tb/sim_sec_access_filter.sv
module sim_sec_access_filter;

  localparam int ADDR_W   = 12;
  localparam int BLK_LOG2 = 5;
  localparam int DATA_W   = 32;
  localparam int NUM_BLK  = 1 << (ADDR_W - BLK_LOG2);
  localparam int LUT_BITS = ((NUM_BLK + 31) / 32) * 32;
  localparam int WORDS    = 1 << (ADDR_W - 2);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 0, reqWrite = 0, reqNonSec = 0, reqAttrKnown = 1;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic [15:0] reqMaster = '0;
  logic [LUT_BITS-1:0] lutBits = '0;
  logic errRespEn = 0, clrFault = 0;
  logic memValid, memWrite, rspValid, rspErr, faultStatus;
  logic [ADDR_W-1:0] memAddr, capAddr;
  logic [DATA_W-1:0] memWdata, rspRdata;
  logic [DATA_W-1:0] memRdata = '0;
  logic [31:0] capInfo;

  always #10 clk = ~clk;

  sec_access_filter #(.ADDR_W(ADDR_W), .BLK_LOG2(BLK_LOG2), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqNonSec(reqNonSec),
    .reqAttrKnown(reqAttrKnown), .reqMaster(reqMaster), .lutBits(lutBits),
    .errRespEn(errRespEn), .clrFault(clrFault), .memValid(memValid),
    .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .rspValid(rspValid), .rspErr(rspErr),
    .rspRdata(rspRdata), .faultStatus(faultStatus), .capAddr(capAddr),
    .capInfo(capInfo)
  );

  // downstream memory model, one cycle read latency
  logic [DATA_W-1:0] mem [WORDS];
  always @(posedge clk) begin
    if (memValid) begin
      if (memWrite) mem[memAddr[ADDR_W-1:2]] <= memWdata;
      else          memRdata <= mem[memAddr[ADDR_W-1:2]];
    end
  end

  typedef struct { logic [DATA_W-1:0] data; logic err; string tag; } exp_t;
  exp_t expQ[$];
  logic [DATA_W-1:0] shadow [WORDS];
  int checks = 0, fails = 0;
  logic expStatus = 0;
  logic [ADDR_W-1:0] expCapAddr = '0;
  logic [31:0] expCapInfo = '0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) check("R4 unexpected response", 1, 0);
      else begin
        exp_t e;
        e = expQ.pop_front();
        check({e.tag, " rdata"}, rspRdata, e.data);
        check({e.tag, " err"}, rspErr, e.err);
      end
    end
  end

  // driver: one request, then idle; returns on the negedge after the response
  task automatic issue(input logic wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                       input logic ns, input logic known, input logic [15:0] mst, input string tag);
    logic effNs, bitv, pass;
    exp_t e;
    effNs = known & ns;
    bitv  = lutBits[a[ADDR_W-1:BLK_LOG2]];
    pass  = (bitv == effNs);
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = wd;
    reqNonSec = ns; reqAttrKnown = known; reqMaster = mst;
    #1;
    check({tag, " R4/R5 memValid"}, memValid, pass);
    e.data = (pass && !wr) ? shadow[a[ADDR_W-1:2]] : '0;
    e.err  = !pass && errRespEn;
    e.tag  = tag;
    expQ.push_back(e);
    if (pass && wr) shadow[a[ADDR_W-1:2]] = wd;
    if (!pass && !expStatus) begin
      expStatus = 1; expCapAddr = a;
      expCapInfo = {14'b0, bitv, effNs, mst};
    end
    @(negedge clk);
    reqValid = 0; reqWrite = 0;
    #1;
  endtask

  task automatic checkCap(input string tag);
    check({tag, " status"}, faultStatus, expStatus);
    check({tag, " capAddr"}, capAddr, expCapAddr);
    check({tag, " capInfo"}, capInfo, expCapInfo);
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) begin mem[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R10 reset state
    check("R10 rspValid", rspValid, 0);
    check("R10 rspErr", rspErr, 0);
    checkCap("R10");

    // R2: table zero, secure passes, non-secure refused
    issue(1, 12'h040, 32'hA5A5_0001, 0, 1, 16'h0011, "R2 sec write");
    issue(0, 12'h040, '0, 0, 1, 16'h0011, "R4 sec read");
    issue(0, 12'h044, '0, 1, 1, 16'h0022, "R5 ns read blocked");
    checkCap("R7 first capture");
    // R8: second refusal does not overwrite
    issue(1, 12'h040, 32'hDEAD_BEEF, 1, 1, 16'h0033, "R5 ns write blocked");
    checkCap("R8 hold");
    issue(0, 12'h040, '0, 0, 1, 16'h0011, "R5 write dropped readback");

    // R9 clear
    @(negedge clk); clrFault = 1;
    @(negedge clk); clrFault = 0; expStatus = 0;
    #1;
    checkCap("R9 clear");

    // R1: block 100 is word 3 bit 4, block 5 is word 0 bit 5
    lutBits[3*32 + 4] = 1'b1;
    lutBits[5] = 1'b1;
    errRespEn = 1;
    issue(1, 12'(100 << BLK_LOG2), 32'h1234_5678, 1, 1, 16'h0044, "R1 ns write block100");
    issue(0, 12'(100 << BLK_LOG2), '0, 1, 1, 16'h0044, "R1 ns read block100");
    issue(0, 12'(100 << BLK_LOG2) + 12'h4, '0, 0, 1, 16'h0055, "R6 sec blocked err");
    checkCap("R7 capture cfg bit");
    issue(0, 12'(5 << BLK_LOG2) + 12'h8, '0, 0, 1, 16'h0066, "R6 err while set");
    checkCap("R8 hold err");

    // R9: clear together with refusal while set - no capture
    @(negedge clk);
    clrFault = 1;
    reqValid = 1; reqWrite = 0; reqAddr = 12'h0A0; reqNonSec = 0; reqAttrKnown = 1;
    begin
      exp_t e; e.data = '0; e.err = 1; e.tag = "R9 clear+block"; expQ.push_back(e);
    end
    @(negedge clk);
    clrFault = 0; reqValid = 0; expStatus = 0;
    #1;
    checkCap("R9 clear wins");

    // R3: unknown attribute with nonSec=1 counts as secure
    errRespEn = 0;
    issue(0, 12'h040, '0, 1, 0, 16'h0077, "R3 unknown passes on secure block");
    issue(0, 12'(6 << BLK_LOG2), '0, 1, 1, 16'h0077, "R3 known ns blocked");
    checkCap("R7 second capture");
    @(negedge clk); clrFault = 1;
    @(negedge clk); clrFault = 0; expStatus = 0;
    issue(1, 12'(5 << BLK_LOG2), 32'h0BAD, 1, 0, 16'h0088, "R3 unknown blocked on ns block");
    checkCap("R3 capture ns flag zero");

    repeat (3) @(negedge clk);
    check("R4 queue drained", expQ.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R4 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule